// File: doc/BRIEF.md
# Byte-to-Word Dual-Clock FIFO

This block moves a stream of bytes from a fast producer clock domain into a slower consumer clock domain and regroups it on the way: every four bytes written come out as one 32-bit word. The producer presents a byte with a write strobe whenever the full flag is low. The consumer pulls one word per accepted read strobe whenever the empty flag is low. The two clocks have no phase or frequency relation, for example 155 MHz on the write side and 50 MHz on the read side.

Both pointers carry one extra wrap bit above the address bits. As a result, all locations of the storage array can be occupied at once. The write pointer counts bytes and the read pointer counts words. Each pointer crosses to the other domain in Gray code through a two-stage synchronizer. Because of that crossing delay the flags are conservative: full may stay high, and empty may stay high, for a few cycles after the other side has already moved.

The read side only sees complete words. One to three trailing bytes stay hidden behind the empty flag until the byte that completes their word arrives. The storage holds 4 x 2^WORD_AW bytes.

Top module: `byte_to_word_fifo`

## Requirements
- R1: While rst_ni is low, and after its release, the block shows empty_o=1, full_o=0 and rd_data_o=0.
- R2: Bytes are packed little-endian. Within a word, the first byte written appears in rd_data_o[7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R3: With no reads, exactly 4 x 2^WORD_AW bytes (32 with defaults) are accepted. full_o stays low after 31 writes and is high right after the write clock edge that stores byte 32.
- R4: A write strobe while full_o is high stores nothing and moves no pointer. After the FIFO is drained, no extra word appears and the stored words are unchanged.
- R5: empty_o stays high while fewer than four unread bytes are stored, however long the reader waits.
- R6: A read strobe while empty_o is high is ignored. rd_data_o keeps its value and the read position does not move.
- R7: rd_data_o changes only on a read clock edge where a read was accepted. The new word is valid right after that edge.
- R8: Flag release latency is bounded. empty_o falls within three read clock cycles after the write that completes a word. full_o falls within three write clock cycles after a read that frees a word.
- R9: Word order and content are preserved across repeated wraps of both pointers. Each Gray-coded pointer changes at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write-side clock |
| rd_clk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Byte to store |
| full_o | output | 1 | No room for another byte |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered output word |
| empty_o | output | 1 | No complete word available |

## Verification
The hardest state to reach is a partially filled word sitting in the buffer while the reader keeps asking for data. It takes three bytes written, enough read cycles for the pointer to cross the domains, and then a read strobe that must be ignored. The stimulus builds exactly that state and probes it. It then writes the completing byte, which proves the ignored read did not move the position. The stimulus also pushes the FIFO through three full fill-and-drain passes, each with an extra byte offered while full, so that both wrap bits flip.

// File: rtl/b2w_pkg.sv
package b2w_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 2;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/b2w_sync.sv
module b2w_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/b2w_wr_ctrl.sv
module b2w_wr_ctrl #(
  parameter int unsigned WORD_AW = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [WORD_AW:0]         rgray_i,
  output logic                     full_o,
  output logic                     wr_ok_o,
  output logic [WORD_AW+1:0]       waddr_o,
  output logic [WORD_AW+2:0]       wgray_o
);
  localparam int unsigned AW = WORD_AW + 2;

  logic [AW:0]      wptr_q, wptr_nx, wgray_q;
  logic [WORD_AW:0] rbin;

  // Gray to binary of the synchronized read word pointer
  always_comb begin
    rbin[WORD_AW] = rgray_i[WORD_AW];
    for (int i = int'(WORD_AW) - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_i[i];
  end

  // full: byte pointer is one lap ahead of the read word pointer
  assign full_o  = (wptr_q == {~rbin[WORD_AW], rbin[WORD_AW-1:0], 2'b00});
  assign wr_ok_o = wr_en_i & ~full_o;
  assign wptr_nx = wr_ok_o ? wptr_q + 1'b1 : wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_nx;
      wgray_q <= wptr_nx ^ (wptr_nx >> 1);
    end
  end

  assign waddr_o = wptr_q[AW-1:0];
  assign wgray_o = wgray_q;
endmodule

// File: rtl/b2w_rd_ctrl.sv
module b2w_rd_ctrl #(
  parameter int unsigned WORD_AW = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [WORD_AW+2:0]   wgray_i,
  output logic                 empty_o,
  output logic                 rd_ok_o,
  output logic [WORD_AW-1:0]   raddr_o,
  output logic [WORD_AW:0]     rgray_o
);
  localparam int unsigned AW = WORD_AW + 2;

  logic [AW:0]      wbin, fill;
  logic [WORD_AW:0] rptr_q, rptr_nx, rgray_q;

  always_comb begin
    wbin[AW] = wgray_i[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
  end

  // bytes visible to the reader; a partial word keeps empty high
  assign fill    = wbin - {rptr_q, 2'b00};
  assign empty_o = (fill < (AW+1)'(4));
  assign rd_ok_o = rd_en_i & ~empty_o;
  assign rptr_nx = rd_ok_o ? rptr_q + 1'b1 : rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
    end else begin
      rptr_q  <= rptr_nx;
      rgray_q <= rptr_nx ^ (rptr_nx >> 1);
    end
  end

  assign raddr_o = rptr_q[WORD_AW-1:0];
  assign rgray_o = rgray_q;
endmodule

// File: rtl/byte_to_word_fifo.sv
module byte_to_word_fifo
  import b2w_pkg::*;
#(
  parameter int unsigned WORD_AW = 3
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic              full_o,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  output logic              empty_o
);
  localparam int unsigned AW    = WORD_AW + LANE_W;
  localparam int unsigned BYTES = 1 << AW;

  byte_t                mem [BYTES];
  logic                 wr_ok, rd_ok;
  logic [AW-1:0]        waddr;
  logic [WORD_AW-1:0]   raddr;
  logic [AW:0]          wgray, wgray_rs;
  logic [WORD_AW:0]     rgray, rgray_ws;

  b2w_wr_ctrl #(.WORD_AW(WORD_AW)) i_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rgray_i(rgray_ws),
    .full_o(full_o), .wr_ok_o(wr_ok), .waddr_o(waddr), .wgray_o(wgray)
  );

  b2w_rd_ctrl #(.WORD_AW(WORD_AW)) i_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .wgray_i(wgray_rs),
    .empty_o(empty_o), .rd_ok_o(rd_ok), .raddr_o(raddr), .rgray_o(rgray)
  );

  b2w_sync #(.W(AW+1)) i_w2r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_rs)
  );

  b2w_sync #(.W(WORD_AW+1)) i_r2w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_ws)
  );

  always_ff @(posedge wr_clk_i) begin
    if (wr_ok) mem[waddr] <= wr_data_i;
  end

  // one output register per byte lane, lane k reads byte k of the word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_t lane_q;
    always_ff @(posedge rd_clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q <= '0;
      else if (rd_ok) lane_q <= mem[{raddr, LANE_W'(g)}];
    end
    assign rd_data_o[BYTE_W*g +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/byte_to_word_fifo_chk.sv
module byte_to_word_fifo_chk #(
  parameter int unsigned WORD_AW = 3
) (
  input logic               wr_clk_i,
  input logic               rd_clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic               full_o,
  input logic               empty_o,
  input logic [31:0]        rd_data_o,
  input logic [WORD_AW+2:0] wgray,
  input logic [WORD_AW:0]   rgray,
  input logic [WORD_AW:0]   rgray_ws
);
  localparam int unsigned AW    = WORD_AW + 2;
  localparam int unsigned BYTES = 1 << AW;

  logic [AW:0]      wbin, fill;
  logic [WORD_AW:0] rbin;

  always_comb begin
    wbin[AW] = wgray[AW];
    for (int i = int'(AW) - 1; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray[i];
    rbin[WORD_AW] = rgray_ws[WORD_AW];
    for (int i = int'(WORD_AW) - 1; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_ws[i];
  end
  assign fill = wbin - {rbin, 2'b00};

  a_r3_no_overflow: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    fill <= (AW+1)'(BYTES));

  a_r4_write_ignored: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wgray));

  a_r6_read_ignored: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> $stable(rgray));

  a_r7_data_hold: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    !(rd_en_i && !empty_o) |=> $stable(rd_data_o));

  a_r9_wgray_step: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r9_rgray_step: assert property (@(posedge rd_clk_i) disable iff (!rst_ni)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind byte_to_word_fifo byte_to_word_fifo_chk #(.WORD_AW(WORD_AW)) i_chk (
  .wr_clk_i(wr_clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .full_o(full_o), .empty_o(empty_o),
  .rd_data_o(rd_data_o), .wgray(wgray), .rgray(rgray), .rgray_ws(rgray_ws)
);

// File: tb/test_byte_to_word_fifo.sv
module test_byte_to_word_fifo;
  logic        wr_clk = 0, rd_clk = 0, rst_ni = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wr_data = '0;
  logic [31:0] rd_data;
  logic        full, empty;
  int          total = 0, bad = 0;

  always #3  wr_clk = ~wr_clk;
  always #10 rd_clk = ~rd_clk;

  byte_to_word_fifo i_byte_to_word_fifo (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .full_o(full),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .empty_o(empty)
  );

  localparam logic [31:0] VEC [6] = '{
    32'h0403_0201, 32'hDEAD_BEEF, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h80_01_7F_FE, 32'hA5C3_3C5A
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge wr_clk); wr_en = 1; wr_data = b;
    @(negedge wr_clk); wr_en = 0;
  endtask

  task automatic get(output logic [31:0] w);
    @(negedge rd_clk); rd_en = 1;
    @(negedge rd_clk); rd_en = 0;
    w = rd_data;
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w, hold;
    repeat (3) @(negedge rd_clk);
    chk(empty === 1'b1, "R1 empty in reset", 32'(empty), 1);
    chk(full === 1'b0, "R1 full in reset", 32'(full), 0);
    rst_ni = 1;
    repeat (2) @(negedge rd_clk);
    chk(empty === 1'b1 && full === 1'b0, "R1 flags after reset", {30'd0, full, empty}, 32'd1);
    chk(rd_data === 32'd0, "R1 data after reset", rd_data, 0);

    // R2 little-endian packing, R8 empty release, R7 data after accepted read
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 4; k++) put(VEC[v][8*k +: 8]);
      repeat (3) @(negedge rd_clk);
      chk(empty === 1'b0, "R8 empty release", 32'(empty), 0);
      get(w);
      chk(w === VEC[v], "R2 packing", w, VEC[v]);
      settle();
      chk(empty === 1'b1, "R2 empty after word", 32'(empty), 1);
    end

    // R5 stranded bytes, R6 ignored read
    put(8'h11); put(8'h22); put(8'h33);
    settle();
    chk(empty === 1'b1, "R5 three bytes stranded", 32'(empty), 1);
    hold = rd_data;
    get(w);
    chk(w === hold, "R6 data kept on empty read", w, hold);
    put(8'h44);
    settle();
    chk(empty === 1'b0, "R5 word completed", 32'(empty), 0);
    get(w);
    chk(w === 32'h4433_2211, "R6 position kept", w, 32'h4433_2211);
    settle();
    chk(empty === 1'b1, "R6 drained", 32'(empty), 1);

    // R3 capacity, R4 write while full, R8 full release, R9 wrap
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 31; i++) put(8'(p * 64 + i + 1));
      chk(full === 1'b0, "R3 not full at 31", 32'(full), 0);
      put(8'(p * 64 + 32));
      chk(full === 1'b1, "R3 full at 32", 32'(full), 1);
      put(8'hEE);
      chk(full === 1'b1, "R4 still full", 32'(full), 1);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] e;
        for (int j = 0; j < 4; j++) e[8*j +: 8] = 8'(p * 64 + 4 * k + j + 1);
        get(w);
        chk(w === e, "R9 order across wrap", w, e);
        if (k == 0) begin
          repeat (3) @(negedge wr_clk);
          chk(full === 1'b0, "R8 full release", 32'(full), 0);
        end
      end
      settle();
      chk(empty === 1'b1, "R4 no extra word", 32'(empty), 1);
      hold = rd_data;
      get(w);
      chk(w === hold, "R7 data hold", w, hold);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule